// File: doc/BRIEF.md
# Prescaled Compare-Match Timer Channel

This block is one up-counting timer channel. Its counter is CNT_W bits wide (16 by default) and advances on ticks taken from the system clock through a selectable divider. Two compare registers, A and B, are checked against the counter on every tick. A hit can do four things: clear the counter, set a status flag, raise the interrupt line when that flag is enabled, and drive a dedicated output pin through a programmable action. The block also holds a start register shared between channels. It has one run bit per channel, and only the bit at index CH_IDX lets this counter advance.

Software reaches the block through a simple synchronous register port. A write strobe with a byte address and a 16-bit write word updates a register at the clock edge. A read strobe returns the addressed register on `rdata` one cycle later. Eight-bit registers use the low byte of the data word and read back zero-extended. The byte offsets are: control 0, mode 1 (stored only), pin action 2, interrupt enable 4, status 5, counter 6, compare A 8, compare B 10 and start 12.

Top module: `ptmr_channel`

## Requirements
- R1: Control bits 7:5 choose what clears the counter. Code 1 is a compare A hit and code 2 is a compare B hit. Every other code, including 5 and 6, never clears. When a clearing hit lands on a tick, the counter takes 0 at that tick instead of counting up.
- R2: Control bits 2:0 set the tick divider. Code 0 gives one tick per clock, 1 one per 4, 2 one per 16, and 3 to 7 one per 64. The first tick comes exactly one divider period after the run bit is set.
- R3: A compare hit occurs on a tick when the counter equals the compare value. It sets status bit 0 for A or status bit 1 for B. With clearing on A and compare value N, the counter repeats the sequence 0..N.
- R4: Pin action register bits 3:0 drive pin A and bits 7:4 drive pin B. The low two bits of a code give the action on each hit: 0 hold, 1 drive low, 2 drive high, 3 invert. Bit 2 of the code is the start level. When a nonzero action is written, the pin takes that start level on the next cycle. A code with action 0 leaves its pin alone.
- R5: A status flag clears only when 0 is written to its bit after a status read has returned it as 1, with no status write in between. Writing 1 to a bit leaves it unchanged.
- R6: `irq` is high exactly when some flag is set and its enable is set. The enables are: enable bit 0 for the A flag, bit 1 for the B flag and bit 4 for the overflow flag.
- R7: The counter advances only while bit CH_IDX of the start register (offset 12) is 1. The other bits of that register are stored and read back, but they do not affect this channel.
- R8: Status bit 4 is set when a tick takes the counter from all ones to 0. It clears by the rule in R5.
- R9: A counter write in the same cycle as a tick wins over both the count-up and the clear.
- R10: After reset, every register, the counter, both pins and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | CNT_W | Write data (low byte for 8-bit registers) |
| rdata | output | CNT_W | Read data, valid the cycle after rd_en |
| pin_a | output | 1 | Output driven by compare A actions |
| pin_b | output | 1 | Output driven by compare B actions |
| irq | output | 1 | Combined enabled-flag interrupt |

## Verification
The main collision is a counter write by software at an edge where the counter also ticks. The bench starts the channel at the fastest divider and writes a new count on the very next edge, so the increment and the write land together. It then stops the channel one edge later and expects the written value plus exactly one. A second collision is a status write arriving just after a hit has set a flag that was never read. The bench checks that this flag survives, and that it clears only after a read has armed it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_MODE = 1;
  localparam int unsigned OFS_IOC  = 2;
  localparam int unsigned OFS_IER  = 4;
  localparam int unsigned OFS_STAT = 5;
  localparam int unsigned OFS_CNT  = 6;
  localparam int unsigned OFS_CMPA = 8;
  localparam int unsigned OFS_CMPB = 10;
  localparam int unsigned OFS_RUN  = 12;

  localparam logic [2:0] CLR_ON_A = 3'd1;
  localparam logic [2:0] CLR_ON_B = 3'd2;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } pin_act_e;

  localparam int unsigned PSC_W = 6;

  // terminal count of the divider for a select code
  function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] sel);
    case (sel)
      3'd0:    psc_limit = 6'd0;
      3'd1:    psc_limit = 6'd3;
      3'd2:    psc_limit = 6'd15;
      default: psc_limit = 6'd63;
    endcase
  endfunction

  // status bit position of flag index (0: A, 1: B, 2: overflow)
  function automatic int unsigned flag_pos(input int unsigned idx);
    flag_pos = (idx == 2) ? 4 : idx;
  endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] lim;

  assign lim  = psc_limit(sel);
  assign tick = run && (div_q >= lim);

  // held at zero while stopped, so every start begins a fresh period
  always_ff @(posedge clk) begin
    if (rst || !run)  div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [2:0]       clr_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt,
  output logic             eq_a,
  output logic             eq_b,
  output logic             hit_a,
  output logic             hit_b,
  output logic             wrap
);
  logic clr_hit;

  assign eq_a    = (cnt == cmp_a);
  assign eq_b    = (cnt == cmp_b);
  assign hit_a   = tick && eq_a;
  assign hit_b   = tick && eq_b;
  assign clr_hit = ((clr_sel == CLR_ON_A) && eq_a) || ((clr_sel == CLR_ON_B) && eq_b);
  assign wrap    = tick && !cnt_we && !clr_hit && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (cnt_we)  cnt <= cnt_wdata;
    else if (tick) begin
      if (clr_hit)    cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_pin.sv
module ptmr_pin
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] cur_code,
  input  logic [3:0] new_code,
  input  logic       code_wr,
  input  logic       hit,
  output logic       pin
);
  pin_act_e act;
  assign act = pin_act_e'(cur_code[1:0]);

  always_ff @(posedge clk) begin
    if (rst)                                   pin <= 1'b0;
    else if (code_wr && (new_code[1:0] != 2'd0)) pin <= new_code[2];
    else if (hit) begin
      case (act)
        ACT_LOW:  pin <= 1'b0;
        ACT_HIGH: pin <= 1'b1;
        ACT_FLIP: pin <= ~pin;
        default:  pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              pin_a,
  output logic              pin_b,
  output logic              irq
);
  localparam int unsigned NUM_CMP  = 2;
  localparam int unsigned NUM_FLAG = 3;

  logic [7:0]        ctrl_q, mode_q, ioc_q, ier_q;
  logic [NUM_CH-1:0] run_q;
  logic [CNT_W-1:0]  cmpa_q, cmpb_q;

  logic wr_ctrl, wr_mode, wr_ioc, wr_ier, wr_run, wr_cmpa, wr_cmpb;
  logic cnt_we, stat_wr, stat_rd;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_mode = wr_en && (addr == ADDR_W'(OFS_MODE));
  assign wr_ioc  = wr_en && (addr == ADDR_W'(OFS_IOC));
  assign wr_ier  = wr_en && (addr == ADDR_W'(OFS_IER));
  assign stat_wr = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign cnt_we  = wr_en && (addr == ADDR_W'(OFS_CNT));
  assign wr_cmpa = wr_en && (addr == ADDR_W'(OFS_CMPA));
  assign wr_cmpb = wr_en && (addr == ADDR_W'(OFS_CMPB));
  assign wr_run  = wr_en && (addr == ADDR_W'(OFS_RUN));
  assign stat_rd = rd_en && (addr == ADDR_W'(OFS_STAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; mode_q <= '0; ioc_q <= '0; ier_q <= '0;
      run_q  <= '0; cmpa_q <= '0; cmpb_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[7:0];
      if (wr_mode) mode_q <= wdata[7:0];
      if (wr_ioc)  ioc_q  <= wdata[7:0];
      if (wr_ier)  ier_q  <= wdata[7:0];
      if (wr_run)  run_q  <= wdata[NUM_CH-1:0];
      if (wr_cmpa) cmpa_q <= wdata;
      if (wr_cmpb) cmpb_q <= wdata;
    end
  end

  logic run, tick;
  logic [2:0] clr_sel;
  assign run     = run_q[CH_IDX];
  assign clr_sel = ctrl_q[7:5];

  ptmr_prescaler u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (ctrl_q[2:0]),
    .tick (tick)
  );

  logic [CNT_W-1:0] cnt;
  logic eq_a, eq_b, hit_a, hit_b, wrap;

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_we    (cnt_we),
    .cnt_wdata (wdata),
    .clr_sel   (clr_sel),
    .cmp_a     (cmpa_q),
    .cmp_b     (cmpb_q),
    .cnt       (cnt),
    .eq_a      (eq_a),
    .eq_b      (eq_b),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .wrap      (wrap)
  );

  // output pins, one action unit per compare
  logic [NUM_CMP-1:0] hits, pins;
  assign hits = {hit_b, hit_a};

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_pin
    ptmr_pin u_pin (
      .clk      (clk),
      .rst      (rst),
      .cur_code (ioc_q[4*g+3:4*g]),
      .new_code (wdata[4*g+3:4*g]),
      .code_wr  (wr_ioc),
      .hit      (hits[g]),
      .pin      (pins[g])
    );
  end

  assign pin_a = pins[0];
  assign pin_b = pins[1];

  // status flags with read-arm / write-zero clearing
  logic [NUM_FLAG-1:0] set_ev, flg, ier_sel;
  assign set_ev = {wrap, hit_b, hit_a};

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    localparam int unsigned P = flag_pos(g);
    logic f_q, arm_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        f_q   <= 1'b0;
        arm_q <= 1'b0;
      end else begin
        if (set_ev[g])                          f_q <= 1'b1;
        else if (stat_wr && !wdata[P] && arm_q) f_q <= 1'b0;
        if (stat_wr)      arm_q <= 1'b0;
        else if (stat_rd) arm_q <= f_q;
      end
    end
    assign flg[g]     = f_q;
    assign ier_sel[g] = ier_q[P];
  end

  assign irq = |(flg & ier_sel);

  logic [7:0] stat_byte;
  assign stat_byte = {3'b000, flg[2], 2'b00, flg[1], flg[0]};

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADDR_W'(OFS_CTRL): rdata <= CNT_W'(ctrl_q);
        ADDR_W'(OFS_MODE): rdata <= CNT_W'(mode_q);
        ADDR_W'(OFS_IOC):  rdata <= CNT_W'(ioc_q);
        ADDR_W'(OFS_IER):  rdata <= CNT_W'(ier_q);
        ADDR_W'(OFS_STAT): rdata <= CNT_W'(stat_byte);
        ADDR_W'(OFS_CNT):  rdata <= cnt;
        ADDR_W'(OFS_CMPA): rdata <= cmpa_q;
        ADDR_W'(OFS_CMPB): rdata <= cmpb_q;
        ADDR_W'(OFS_RUN):  rdata <= CNT_W'(run_q);
        default:           rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ptmr_channel_chk.sv
module ptmr_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             tick,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       clr_sel,
  input logic             eq_a,
  input logic [2:0]       flg,
  input logic             stat_wr,
  input logic [2:0]       ier_sel,
  input logic             irq
);
  // R7: a stopped channel keeps its count unless software writes it
  a_r7_halt: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt));

  // R2: no tick is produced while the run bit is low
  a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  // R1: a clearing compare A hit leaves the counter at zero
  a_r1_clear_a: assert property (@(posedge clk) disable iff (rst)
    (tick && eq_a && clr_sel == 3'd1 && !cnt_we) |=> (cnt == '0));

  // R8: the overflow flag only rises after the counter held all ones
  a_r8_wrap_src: assert property (@(posedge clk) disable iff (rst)
    $rose(flg[2]) |-> ($past(cnt) == {CNT_W{1'b1}}));

  // R5: a compare A flag only falls right after a status write
  a_r5_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(flg[0]) |-> $past(stat_wr));

  // R6: with all enables off the interrupt stays low
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (ier_sel == 3'b000) |-> !irq);
endmodule

bind ptmr_channel ptmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .tick    (tick),
  .cnt_we  (cnt_we),
  .cnt     (cnt),
  .clr_sel (clr_sel),
  .eq_a    (eq_a),
  .flg     (flg),
  .stat_wr (stat_wr),
  .ier_sel (ier_sel),
  .irq     (irq)
);

// File: tb/sim_ptmr_channel.sv
module sim_ptmr_channel;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CNT_W  = 16;

  localparam logic [3:0] A_CTRL = 4'd0, A_IOC = 4'd2, A_IER = 4'd4, A_STAT = 4'd5,
                         A_CNT = 4'd6, A_CMPA = 4'd8, A_CMPB = 4'd10, A_RUN = 4'd12;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_NOP = 2'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0]  wdata = '0;
  logic [CNT_W-1:0]  rdata;
  logic pin_a, pin_b, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ptmr_channel u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .irq(irq)
  );

  // op, addr, data, expected read value; one clock edge per entry
  localparam int NV = 20;
  localparam logic [37:0] VEC [0:NV-1] = '{
    {OP_RD,  A_CTRL, 16'h0000, 16'h0000},  // R10 control after reset
    {OP_RD,  A_CNT,  16'h0000, 16'h0000},  // R10 counter after reset
    {OP_RD,  A_STAT, 16'h0000, 16'h0000},  // R10 status after reset
    {OP_WR,  A_CMPA, 16'h0004, 16'h0000},
    {OP_RD,  A_CMPA, 16'h0000, 16'h0004},  // R3 compare readback
    {OP_WR,  A_CMPB, 16'h0002, 16'h0000},
    {OP_WR,  A_CTRL, 16'h0020, 16'h0000},
    {OP_RD,  A_CTRL, 16'h0000, 16'h0020},  // R1 clear-on-A selected
    {OP_WR,  A_IOC,  16'h0073, 16'h0000},
    {OP_WR,  A_IER,  16'h0001, 16'h0000},
    {OP_WR,  A_RUN,  16'h0001, 16'h0000},
    {OP_RD,  A_CNT,  16'h0000, 16'h0000},  // R3 first tick not yet seen
    {OP_RD,  A_CNT,  16'h0000, 16'h0001},  // R3 counting
    {OP_NOP, A_CTRL, 16'h0000, 16'h0000},
    {OP_RD,  A_STAT, 16'h0000, 16'h0002},  // R3 compare B hit flagged
    {OP_NOP, A_CTRL, 16'h0000, 16'h0000},
    {OP_RD,  A_STAT, 16'h0000, 16'h0003},  // R3 compare A hit flagged
    {OP_RD,  A_CNT,  16'h0000, 16'h0001},  // R1 wrapped through 0 after 4
    {OP_WR,  A_RUN,  16'h0000, 16'h0000},
    {OP_RD,  A_CNT,  16'h0000, 16'h0003}   // R7 frozen after stop
  };

  task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] kind, input logic [3:0] a, input logic [15:0] d,
                    input logic [15:0] exp, input string req);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = (kind == OP_WR);
    rd_en = (kind == OP_RD);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (kind == OP_RD) chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    op(OP_WR, a, d, 16'h0, "");
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string req);
    op(OP_RD, a, 16'h0, exp, req);
  endtask

  task automatic idle();
    op(OP_NOP, 4'd0, 16'h0, 16'h0, "");
  endtask

  // run for m edges: ticks may land on edges 1..m after the start write
  task automatic run_for(input int m);
    wr(A_RUN, 16'h0001);
    for (int k = 0; k < m - 1; k++) idle();
    wr(A_RUN, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic pb_prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 pin_a", 16'(pin_a), 16'h0);
    chk("R10 pin_b", 16'(pin_b), 16'h0);
    chk("R10 irq",   16'(irq),   16'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][37:36], VEC[i][35:32], VEC[i][31:16], VEC[i][15:0], $sformatf("table[%0d]", i));
    end
    chk("R4 pin_a toggled once", 16'(pin_a), 16'h1);
    chk("R4 pin_b toggled twice from 1", 16'(pin_b), 16'h1);
    chk("R6 irq from A flag", 16'(irq), 16'h1);

    // R5: clear after an armed read
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R5 armed flags cleared");
    chk("R6 irq after clear", 16'(irq), 16'h0);
    // new hit, no read before the write
    wr(A_CNT, 16'h0004);
    run_for(1);
    chk("R4 pin_a toggled by hit", 16'(pin_a), 16'h0);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0001, "R5 unread flag survives write of 0");
    wr(A_STAT, 16'h00FF);
    rd(A_STAT, 16'h0001, "R5 writing 1 keeps flag");
    wr(A_STAT, 16'h0000);
    rd(A_STAT, 16'h0000, "R5 read then write 0 clears");

    // R2 dividers
    wr(A_CTRL, 16'h0021);
    wr(A_CNT, 16'h0000);
    run_for(10);
    rd(A_CNT, 16'h0002, "R2 divide by 4");
    wr(A_CTRL, 16'h0027);
    wr(A_CNT, 16'h0000);
    run_for(130);
    rd(A_CNT, 16'h0002, "R2 code 7 divides by 64");

    // R8 overflow
    wr(A_CTRL, 16'h0000);
    wr(A_CNT, 16'hFFFE);
    wr(A_IER, 16'h0010);
    run_for(2);
    rd(A_CNT, 16'h0000, "R8 wrap to zero");
    rd(A_STAT, 16'h0010, "R8 overflow flag");
    chk("R6 irq from overflow", 16'(irq), 16'h1);

    // R9 write collides with a tick
    wr(A_RUN, 16'h0001);
    wr(A_CNT, 16'h0100);
    wr(A_RUN, 16'h0000);
    rd(A_CNT, 16'h0101, "R9 write beats increment");

    // R1 clear sources
    wr(A_CTRL, 16'h0040);
    wr(A_CNT, 16'h0000);
    run_for(6);
    rd(A_CNT, 16'h0000, "R1 clear on B");
    wr(A_CTRL, 16'h00A0);
    wr(A_CNT, 16'h0000);
    run_for(6);
    rd(A_CNT, 16'h0006, "R1 code 5 never clears");

    // R4 start levels
    pb_prev = pin_b;
    wr(A_IOC, 16'h0005);
    chk("R4 A start level 1", 16'(pin_a), 16'h1);
    chk("R4 B hold code leaves pin", 16'(pin_b), 16'(pb_prev));
    wr(A_IOC, 16'h0010);
    chk("R4 A hold code leaves pin", 16'(pin_a), 16'h1);
    chk("R4 B start level 0", 16'(pin_b), 16'h0);

    // R7 other run bits
    wr(A_CNT, 16'h0000);
    wr(A_RUN, 16'h0006);
    for (int k = 0; k < 4; k++) idle();
    rd(A_CNT, 16'h0000, "R7 foreign run bits do not count");
    rd(A_RUN, 16'h0006, "R7 run bits kept");
    wr(A_RUN, 16'h0000);

    // R6 gating
    wr(A_IER, 16'h0000);
    chk("R6 irq masked", 16'(irq), 16'h0);
    wr(A_IER, 16'h0002);
    chk("R6 irq from B flag", 16'(irq), 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule